// File: doc/BRIEF.md
# Interleaved Memory Window Router

This block claims one fixed window of host physical address space and spreads it across up to `N_PORTS` downstream host-bridge ports. Requests arrive with an offset relative to the window. The block adds the programmed window base to form the full host physical address. It slices that address by the interleave granularity and takes the result modulo the configured target count, which picks one downstream port. The request then goes out on that port, still carrying the full host address, its tag, its byte count and its write data.

Setup uses a small write-only register interface. Base, size, granularity encoding, target count and a mask of usable ports are written first. A commit write then checks the size, the granularity and the target count together. If any check fails, the window stays closed and the failures are reported in an error vector.

Some requests cannot be routed: the window is closed, the offset falls beyond the size, the byte count is illegal, or the chosen port is unusable. The block answers these itself through a small local response queue. Reads get zero data and an error flag. Writes get a clean completion. Downstream responses pass straight through and take precedence over local ones, and tags tell the requester which response is which.

Top module: `imw_router`

## Requirements
- R1: After reset the window is closed (`win_en`=0), `cfg_err`=0, no `ds_valid` bit is set, `rsp_valid`=0 and `req_ready`=1.
- R2: A commit (`cfg_sel`=5 with `cfg_wdata[0]`=1) sets `cfg_err[0]` and leaves the window closed when the size (`cfg_sel`=1) is zero or not a whole multiple of 256 MiB.
- R3: The granularity encoding (`cfg_sel`=2, low 4 bits) g selects a stripe of 256<<g bytes. If it was never written, g=0 (256 bytes). A committed g above 6 sets `cfg_err[1]`.
- R4: A committed target count (`cfg_sel`=3) other than 1, 2, 4 or 8 sets `cfg_err[2]`. All failing checks of one commit are reported together. A commit with no failure opens the window with `cfg_err`=0, and `cfg_sel`=5 with `cfg_wdata[0]`=0 closes it.
- R5: Any write to base (`cfg_sel`=0), size, granularity, count or port mask (`cfg_sel`=4, bit p marks port p usable) closes the window until the next commit.
- R6: A routable request shows up two clock edges after acceptance on exactly one `ds_valid` bit, with `ds_addr` = base + offset.
- R7: The chosen port index is ((base + offset) >> (8 + g)) modulo the target count.
- R8: A read is unroutable when the window is closed, when offset >= size, when `req_bytes` is outside 1..8, or when the chosen port's mask bit is 0. Such a read is answered with `rsp_data`=0 and `rsp_err`=1 and is not forwarded.
- R9: An unroutable write is not forwarded and is answered with `rsp_err`=0.
- R10: Accesses of 1 to 8 bytes at any alignment are forwarded with tag, direction, byte count and little-endian data lanes unchanged.
- R11: A downstream response appears on `rsp_*` one edge later and has priority. Local responses wait in a queue of `LQ_DEPTH` entries and leave in order. `req_ready` drops while the queue could overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setup register write strobe |
| cfg_sel | input | 3 | Setup register select |
| cfg_wdata | input | ADDR_W | Setup write data |
| win_en | output | 1 | Window open |
| cfg_err | output | 3 | Commit check failures: size, granularity, count |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tag | input | TAG_W | Request tag |
| req_offset | input | ADDR_W | Window-relative offset |
| req_bytes | input | 4 | Access length in bytes |
| req_wdata | input | DATA_W | Write data, byte 0 in bits 7:0 |
| ds_valid | output | N_PORTS | One-hot forward strobe per port |
| ds_addr | output | ADDR_W | Host physical address |
| ds_write | output | 1 | Forwarded direction |
| ds_tag | output | TAG_W | Forwarded tag |
| ds_bytes | output | 4 | Forwarded length |
| ds_wdata | output | DATA_W | Forwarded write data |
| ds_rsp_valid | input | 1 | Downstream response valid |
| ds_rsp_tag | input | TAG_W | Downstream response tag |
| ds_rsp_data | input | DATA_W | Downstream read data |
| ds_rsp_err | input | 1 | Downstream error flag |
| rsp_valid | output | 1 | Response to requester valid |
| rsp_tag | output | TAG_W | Response tag |
| rsp_data | output | DATA_W | Response data |
| rsp_err | output | 1 | Response error flag |

## Verification
A response passed through from downstream and a locally generated error or completion can fall due in the same cycle. The bench provokes this by holding downstream responses on the input across the cycles in which an unroutable read is due. It checks, edge by edge, that every downstream tag comes out first and that the zero-data error follows once the input goes quiet. A longer stall fills the local queue. The bench then checks that exactly `LQ_DEPTH` requests get in before `req_ready` drops, and that the queued answers drain in acceptance order.

// File: rtl/imw_pkg.sv
package imw_pkg;

  typedef enum logic [2:0] {
    SEL_BASE   = 3'd0,
    SEL_SIZE   = 3'd1,
    SEL_GRAN   = 3'd2,
    SEL_COUNT  = 3'd3,
    SEL_PORTS  = 3'd4,
    SEL_COMMIT = 3'd5
  } cfg_sel_e;

  localparam int ERR_SIZE = 0;
  localparam int ERR_GRAN = 1;
  localparam int ERR_WAYS = 2;
  localparam int ERR_W    = 3;

  // smallest stripe is 2**8 bytes
  localparam int STRIPE_BASE_LOG2 = 8;

endpackage

// File: rtl/imw_cfg_regs.sv
module imw_cfg_regs import imw_pkg::*; #(
  parameter int ADDR_W          = 40,
  parameter int N_PORTS         = 8,
  parameter int GRAN_W          = 4,
  parameter int MAX_GRAN_ENC    = 6,
  parameter int SIZE_ALIGN_LOG2 = 28,
  localparam int CNT_W = $clog2(N_PORTS) + 2,
  localparam int WL_W  = $clog2(CNT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] size_q,
  output logic [GRAN_W-1:0] gran_q,
  output logic [WL_W-1:0]   ways_l2_q,
  output logic [N_PORTS-1:0] port_ok_q,
  output logic              win_en_q,
  output logic [ERR_W-1:0]  cfg_err_q
);

  logic [GRAN_W-1:0] gran_raw;
  logic [CNT_W-1:0]  cnt_raw;
  logic [WL_W-1:0]   ways_l2;
  logic [ERR_W-1:0]  chk_err;
  logic              cnt_pow2;

  // index of the highest set bit of the count
  always_comb begin
    ways_l2 = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (cnt_raw[i]) ways_l2 = WL_W'(i);
    end
  end

  assign cnt_pow2 = (cnt_raw != '0) && ((cnt_raw & (cnt_raw - 1'b1)) == '0);

  always_comb begin
    chk_err           = '0;
    chk_err[ERR_SIZE] = (size_q == '0) || (size_q[SIZE_ALIGN_LOG2-1:0] != '0);
    chk_err[ERR_GRAN] = gran_raw > GRAN_W'(MAX_GRAN_ENC);
    chk_err[ERR_WAYS] = !cnt_pow2 || (cnt_raw > CNT_W'(N_PORTS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      size_q    <= '0;
      gran_raw  <= '0;
      cnt_raw   <= CNT_W'(1);
      port_ok_q <= '0;
      gran_q    <= '0;
      ways_l2_q <= '0;
      win_en_q  <= 1'b0;
      cfg_err_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_BASE:  begin base_q    <= cfg_wdata;                 win_en_q <= 1'b0; end
        SEL_SIZE:  begin size_q    <= cfg_wdata;                 win_en_q <= 1'b0; end
        SEL_GRAN:  begin gran_raw  <= cfg_wdata[GRAN_W-1:0];     win_en_q <= 1'b0; end
        SEL_COUNT: begin cnt_raw   <= cfg_wdata[CNT_W-1:0];      win_en_q <= 1'b0; end
        SEL_PORTS: begin port_ok_q <= cfg_wdata[N_PORTS-1:0];    win_en_q <= 1'b0; end
        SEL_COMMIT: begin
          if (cfg_wdata[0]) begin
            cfg_err_q <= chk_err;
            win_en_q  <= (chk_err == '0);
            gran_q    <= gran_raw;
            ways_l2_q <= ways_l2;
          end else begin
            cfg_err_q <= '0;
            win_en_q  <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/imw_decode.sv
module imw_decode import imw_pkg::*; #(
  parameter int ADDR_W  = 40,
  parameter int N_PORTS = 8,
  parameter int TAG_W   = 8,
  parameter int DATA_W  = 64,
  parameter int GRAN_W  = 4,
  parameter int WL_W    = 3,
  parameter int BYTES_W = 4,
  localparam int MAX_BYTES = DATA_W / 8,
  localparam int PIDX_W    = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_write,
  input  logic [TAG_W-1:0]   in_tag,
  input  logic [ADDR_W-1:0]  in_offset,
  input  logic [BYTES_W-1:0] in_bytes,
  input  logic [DATA_W-1:0]  in_wdata,
  input  logic [ADDR_W-1:0]  base,
  input  logic [ADDR_W-1:0]  size,
  input  logic [GRAN_W-1:0]  gran,
  input  logic [WL_W-1:0]    ways_l2,
  input  logic [N_PORTS-1:0] port_ok,
  input  logic               win_en,
  output logic               s1_valid,
  output logic [N_PORTS-1:0] ds_valid,
  output logic [ADDR_W-1:0]  ds_addr,
  output logic               ds_write,
  output logic [TAG_W-1:0]   ds_tag,
  output logic [BYTES_W-1:0] ds_bytes,
  output logic [DATA_W-1:0]  ds_wdata,
  output logic               push_valid,
  output logic [TAG_W-1:0]   push_tag,
  output logic               push_write
);

  // stage 1: host address and range/length qualification
  logic [ADDR_W-1:0]  s1_hpa;
  logic               s1_write;
  logic [TAG_W-1:0]   s1_tag;
  logic [BYTES_W-1:0] s1_bytes;
  logic [DATA_W-1:0]  s1_wdata;
  logic               s1_ok;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
    s1_hpa   <= base + in_offset;
    s1_write <= in_write;
    s1_tag   <= in_tag;
    s1_bytes <= in_bytes;
    s1_wdata <= in_wdata;
    s1_ok    <= win_en && (in_offset < size) && (in_bytes != '0)
                && (in_bytes <= BYTES_W'(MAX_BYTES));
  end

  // stage 2: stripe index modulo the (power of two) target count
  logic [ADDR_W-1:0] stripe;
  logic [PIDX_W-1:0] idx_mask;
  logic [PIDX_W-1:0] sel_idx;
  logic              routable;

  assign stripe = s1_hpa >> (STRIPE_BASE_LOG2 + int'(gran));

  always_comb begin
    for (int i = 0; i < PIDX_W; i++) begin
      idx_mask[i] = (i < int'(ways_l2));
    end
  end

  assign sel_idx  = stripe[PIDX_W-1:0] & idx_mask;
  assign routable = s1_valid && s1_ok && win_en && port_ok[sel_idx];

  assign push_valid = s1_valid && !routable;
  assign push_tag   = s1_tag;
  assign push_write = s1_write;

  always_ff @(posedge clk) begin
    if (rst)           ds_valid <= '0;
    else if (routable) ds_valid <= N_PORTS'(1) << sel_idx;
    else               ds_valid <= '0;
    ds_addr  <= s1_hpa;
    ds_write <= s1_write;
    ds_tag   <= s1_tag;
    ds_bytes <= s1_bytes;
    ds_wdata <= s1_wdata;
  end

endmodule

// File: rtl/imw_rsp_merge.sv
module imw_rsp_merge #(
  parameter int TAG_W    = 8,
  parameter int DATA_W   = 64,
  parameter int LQ_DEPTH = 4,
  localparam int PTR_W = (LQ_DEPTH > 1) ? $clog2(LQ_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic              push_write,
  input  logic              ds_rsp_valid,
  input  logic [TAG_W-1:0]  ds_rsp_tag,
  input  logic [DATA_W-1:0] ds_rsp_data,
  input  logic              ds_rsp_err,
  output logic [PTR_W:0]    lq_count,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err
);

  // entry: {write, tag}; no reset so it maps onto distributed RAM
  logic [TAG_W:0]   lq_mem [LQ_DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [TAG_W:0]   head;
  logic             pop;

  assign head = lq_mem[rd_ptr];
  assign pop  = !ds_rsp_valid && (lq_count != '0);

  always_ff @(posedge clk) begin
    if (push_valid) lq_mem[wr_ptr] <= {push_write, push_tag};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      lq_count  <= '0;
      rsp_valid <= 1'b0;
      rsp_tag   <= '0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      if (push_valid) wr_ptr <= (wr_ptr == PTR_W'(LQ_DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)        rd_ptr <= (rd_ptr == PTR_W'(LQ_DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      lq_count <= lq_count + (PTR_W+1)'(push_valid) - (PTR_W+1)'(pop);
      if (ds_rsp_valid) begin
        rsp_valid <= 1'b1;
        rsp_tag   <= ds_rsp_tag;
        rsp_data  <= ds_rsp_data;
        rsp_err   <= ds_rsp_err;
      end else if (pop) begin
        rsp_valid <= 1'b1;
        rsp_tag   <= head[TAG_W-1:0];
        rsp_data  <= '0;
        rsp_err   <= !head[TAG_W];
      end else begin
        rsp_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/imw_router.sv
module imw_router import imw_pkg::*; #(
  parameter int ADDR_W          = 40,
  parameter int N_PORTS         = 8,
  parameter int TAG_W           = 8,
  parameter int DATA_W          = 64,
  parameter int LQ_DEPTH        = 4,
  parameter int MAX_GRAN_ENC    = 6,
  parameter int SIZE_ALIGN_LOG2 = 28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [ADDR_W-1:0]  cfg_wdata,
  output logic               win_en,
  output logic [2:0]         cfg_err,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [TAG_W-1:0]   req_tag,
  input  logic [ADDR_W-1:0]  req_offset,
  input  logic [3:0]         req_bytes,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic [N_PORTS-1:0] ds_valid,
  output logic [ADDR_W-1:0]  ds_addr,
  output logic               ds_write,
  output logic [TAG_W-1:0]   ds_tag,
  output logic [3:0]         ds_bytes,
  output logic [DATA_W-1:0]  ds_wdata,
  input  logic               ds_rsp_valid,
  input  logic [TAG_W-1:0]   ds_rsp_tag,
  input  logic [DATA_W-1:0]  ds_rsp_data,
  input  logic               ds_rsp_err,
  output logic               rsp_valid,
  output logic [TAG_W-1:0]   rsp_tag,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rsp_err
);

  localparam int GRAN_W = 4;
  localparam int CNT_W  = $clog2(N_PORTS) + 2;
  localparam int WL_W   = $clog2(CNT_W);
  localparam int PTR_W  = (LQ_DEPTH > 1) ? $clog2(LQ_DEPTH) : 1;

  logic [ADDR_W-1:0]  base, size;
  logic [GRAN_W-1:0]  gran;
  logic [WL_W-1:0]    ways_l2;
  logic [N_PORTS-1:0] port_ok;
  logic               s1_valid;
  logic               push_valid, push_write;
  logic [TAG_W-1:0]   push_tag;
  logic [PTR_W:0]     lq_count;
  logic [PTR_W+1:0]   occupancy;
  logic               accept;

  // queue slots already claimed: stored entries plus the one in stage 1
  assign occupancy = (PTR_W+2)'(lq_count) + (PTR_W+2)'(s1_valid);
  assign req_ready = occupancy < (PTR_W+2)'(LQ_DEPTH);
  assign accept    = req_valid && req_ready;

  imw_cfg_regs #(
    .ADDR_W(ADDR_W), .N_PORTS(N_PORTS), .GRAN_W(GRAN_W),
    .MAX_GRAN_ENC(MAX_GRAN_ENC), .SIZE_ALIGN_LOG2(SIZE_ALIGN_LOG2)
  ) cfg_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .base_q(base), .size_q(size), .gran_q(gran), .ways_l2_q(ways_l2),
    .port_ok_q(port_ok), .win_en_q(win_en), .cfg_err_q(cfg_err)
  );

  imw_decode #(
    .ADDR_W(ADDR_W), .N_PORTS(N_PORTS), .TAG_W(TAG_W), .DATA_W(DATA_W),
    .GRAN_W(GRAN_W), .WL_W(WL_W), .BYTES_W(4)
  ) dec_i (
    .clk(clk), .rst(rst), .in_valid(accept), .in_write(req_write), .in_tag(req_tag),
    .in_offset(req_offset), .in_bytes(req_bytes), .in_wdata(req_wdata),
    .base(base), .size(size), .gran(gran), .ways_l2(ways_l2), .port_ok(port_ok),
    .win_en(win_en), .s1_valid(s1_valid), .ds_valid(ds_valid), .ds_addr(ds_addr),
    .ds_write(ds_write), .ds_tag(ds_tag), .ds_bytes(ds_bytes), .ds_wdata(ds_wdata),
    .push_valid(push_valid), .push_tag(push_tag), .push_write(push_write)
  );

  imw_rsp_merge #(
    .TAG_W(TAG_W), .DATA_W(DATA_W), .LQ_DEPTH(LQ_DEPTH)
  ) rsp_i (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_tag(push_tag),
    .push_write(push_write), .ds_rsp_valid(ds_rsp_valid), .ds_rsp_tag(ds_rsp_tag),
    .ds_rsp_data(ds_rsp_data), .ds_rsp_err(ds_rsp_err), .lq_count(lq_count),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

endmodule

// File: rtl/imw_router_chk.sv
module imw_router_chk #(
  parameter int N_PORTS = 8,
  parameter int TAG_W   = 8,
  parameter int DATA_W  = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_we,
  input logic [2:0]         cfg_sel,
  input logic               win_en,
  input logic [2:0]         cfg_err,
  input logic [N_PORTS-1:0] ds_valid,
  input logic [3:0]         ds_bytes,
  input logic [N_PORTS-1:0] port_ok,
  input logic               ds_rsp_valid,
  input logic [TAG_W-1:0]   ds_rsp_tag,
  input logic [DATA_W-1:0]  ds_rsp_data,
  input logic               ds_rsp_err,
  input logic               rsp_valid,
  input logic [TAG_W-1:0]   rsp_tag,
  input logic [DATA_W-1:0]  rsp_data,
  input logic               rsp_err
);

  a_r6_one_port: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ds_valid));

  a_r8_usable_port: assert property (@(posedge clk) disable iff (rst)
    (ds_valid != '0) |-> ((ds_valid & ~$past(port_ok)) == '0));

  a_r10_legal_len: assert property (@(posedge clk) disable iff (rst)
    (ds_valid != '0) |-> (ds_bytes != 4'd0 && ds_bytes <= 4'd8));

  a_r4_err_closes: assert property (@(posedge clk) disable iff (rst)
    (cfg_err != 3'b000) |-> !win_en);

  a_r5_write_closes: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && cfg_we && cfg_sel < 3'd5) |-> !win_en);

  a_r11_ds_priority: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && ds_rsp_valid) |-> (rsp_valid && rsp_tag == $past(ds_rsp_tag)
      && rsp_data == $past(ds_rsp_data) && rsp_err == $past(ds_rsp_err)));

  a_r8_local_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(ds_rsp_valid)) |-> (rsp_data == '0));

endmodule

bind imw_router imw_router_chk #(
  .N_PORTS(N_PORTS), .TAG_W(TAG_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .win_en(win_en),
  .cfg_err(cfg_err), .ds_valid(ds_valid), .ds_bytes(ds_bytes), .port_ok(port_ok),
  .ds_rsp_valid(ds_rsp_valid), .ds_rsp_tag(ds_rsp_tag), .ds_rsp_data(ds_rsp_data),
  .ds_rsp_err(ds_rsp_err), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
  .rsp_data(rsp_data), .rsp_err(rsp_err)
);

// File: tb/imw_router_tb_top.sv
`timescale 1ns/1ps
module imw_router_tb_top;

  localparam int LQ_DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [39:0] cfg_wdata = '0;
  logic        win_en;
  logic [2:0]  cfg_err;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_tag = '0;
  logic [39:0] req_offset = '0;
  logic [3:0]  req_bytes = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  ds_valid;
  logic [39:0] ds_addr;
  logic        ds_write;
  logic [7:0]  ds_tag;
  logic [3:0]  ds_bytes;
  logic [63:0] ds_wdata;
  logic        ds_rsp_valid = 1'b0;
  logic [7:0]  ds_rsp_tag = '0;
  logic [63:0] ds_rsp_data = '0;
  logic        ds_rsp_err = 1'b0;
  logic        rsp_valid;
  logic [7:0]  rsp_tag;
  logic [63:0] rsp_data;
  logic        rsp_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [7:0]  tag_ctr = 8'h01;
  logic [39:0] base_v  = 40'h03_0000_1300;
  logic [39:0] size_v  = 40'h00_4000_0000;

  always #4 clk = ~clk;

  imw_router #(.LQ_DEPTH(LQ_DEPTH)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .win_en(win_en), .cfg_err(cfg_err), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_tag(req_tag), .req_offset(req_offset),
    .req_bytes(req_bytes), .req_wdata(req_wdata), .ds_valid(ds_valid),
    .ds_addr(ds_addr), .ds_write(ds_write), .ds_tag(ds_tag), .ds_bytes(ds_bytes),
    .ds_wdata(ds_wdata), .ds_rsp_valid(ds_rsp_valid), .ds_rsp_tag(ds_rsp_tag),
    .ds_rsp_data(ds_rsp_data), .ds_rsp_err(ds_rsp_err), .rsp_valid(rsp_valid),
    .rsp_tag(rsp_tag), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [39:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input bit wr, input logic [7:0] tg, input logic [39:0] off,
                      input logic [3:0] nb, input logic [63:0] wd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_tag = tg;
    req_offset = off; req_bytes = nb; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // routed: forward visible at the second negedge after the drive
  task automatic expect_route(input bit wr, input logic [39:0] off, input logic [3:0] nb,
                              input logic [63:0] wd, input int idx, input string rq);
    logic [7:0] tg;
    logic [7:0] exp_v;
    tg = tag_ctr; tag_ctr++;
    exp_v = 8'(1) << idx;
    send(wr, tg, off, nb, wd);
    @(negedge clk);
    chk(ds_valid == exp_v, rq, "port", 64'(ds_valid), 64'(exp_v));
    chk(ds_addr == base_v + off, "R6", "hpa", 64'(ds_addr), 64'(base_v + off));
    chk(ds_tag == tg && ds_write == wr && ds_bytes == nb && ds_wdata == wd,
        "R10", "fields", ds_wdata, wd);
  endtask

  task automatic expect_local(input bit wr, input logic [39:0] off, input logic [3:0] nb,
                              input string rq);
    logic [7:0] tg;
    bit seen_ds;
    bit found;
    logic [7:0]  t;
    logic [63:0] d;
    logic        e;
    tg = tag_ctr; tag_ctr++;
    seen_ds = 1'b0; found = 1'b0; t = '0; d = '0; e = 1'b0;
    send(wr, tg, off, nb, 64'hDEAD_BEEF_0BAD_F00D);
    for (int i = 0; i < 10 && !found; i++) begin
      @(negedge clk);
      if (ds_valid != '0) seen_ds = 1'b1;
      if (rsp_valid) begin found = 1'b1; t = rsp_tag; d = rsp_data; e = rsp_err; end
    end
    chk(found && t == tg, rq, "local tag", 64'(t), 64'(tg));
    chk(d == '0 && e == !wr, rq, "local data/err", {d[62:0], e}, 64'(!wr));
    chk(!seen_ds, rq, "not forwarded", 64'(seen_ds), 64'd0);
  endtask

  task automatic commit_expect(input logic [2:0] err, input string rq);
    cfg_write(3'd5, 40'd1);
    chk(cfg_err == err && win_en == (err == 3'b000), rq, "commit",
        {60'd0, win_en, cfg_err}, {60'd0, (err == 3'b000), err});
  endtask

  function automatic int port_of(input logic [39:0] off, input int g, input int w);
    logic [39:0] hpa;
    hpa = base_v + off;
    return int'((hpa >> (8 + g)) % 40'(w));
  endfunction

  initial begin
    #(8ns * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!win_en && cfg_err == 0 && ds_valid == 0 && !rsp_valid && req_ready, "R1",
        "reset", {56'd0, ds_valid}, 64'd0);

    // R3 default granularity: never written, count 2
    cfg_write(3'd0, base_v);
    cfg_write(3'd1, size_v);
    cfg_write(3'd4, 40'hFF);
    cfg_write(3'd3, 40'd2);
    commit_expect(3'b000, "R4");
    for (int k = 0; k < 6; k++) begin
      logic [39:0] off;
      off = 40'(k * 256 + 5);
      expect_route(k[0], off, 4'd4, 64'(k) * 64'h0101, port_of(off, 0, 2), "R3");
    end

    // R7 sweep: every granularity and every legal count
    for (int g = 0; g < 7; g++) begin
      for (int wi = 0; wi < 4; wi++) begin
        int w;
        w = 1 << wi;
        cfg_write(3'd2, 40'(g));
        cfg_write(3'd3, 40'(w));
        commit_expect(3'b000, "R4");
        for (int k = 0; k < 8; k++) begin
          logic [39:0] off;
          off = 40'(k * (256 << g) + k * 3);
          expect_route(k[0], off, 4'd8, {32'(g), 32'(k)}, port_of(off, g, w), "R7");
        end
      end
    end

    // R2 / R3 / R4 setup checks
    cfg_write(3'd2, 40'd0);
    cfg_write(3'd3, 40'd4);
    cfg_write(3'd1, 40'h00_0800_0000);
    commit_expect(3'b001, "R2");
    cfg_write(3'd1, 40'h00_1000_0001);
    commit_expect(3'b001, "R2");
    cfg_write(3'd1, 40'd0);
    commit_expect(3'b001, "R2");
    cfg_write(3'd1, size_v);
    cfg_write(3'd2, 40'd7);
    commit_expect(3'b010, "R3");
    cfg_write(3'd2, 40'd6);
    commit_expect(3'b000, "R3");
    cfg_write(3'd3, 40'd3);
    commit_expect(3'b100, "R4");
    cfg_write(3'd3, 40'd0);
    commit_expect(3'b100, "R4");
    cfg_write(3'd3, 40'd16);
    commit_expect(3'b100, "R4");
    cfg_write(3'd1, 40'd5);
    cfg_write(3'd2, 40'd9);
    cfg_write(3'd3, 40'd6);
    commit_expect(3'b111, "R4");
    expect_local(1'b0, 40'h40, 4'd4, "R8");

    // restore: gran 0, count 4
    cfg_write(3'd1, size_v);
    cfg_write(3'd2, 40'd0);
    cfg_write(3'd3, 40'd4);
    commit_expect(3'b000, "R4");

    // R5 a setup write closes the window
    cfg_write(3'd0, base_v);
    chk(!win_en, "R5", "closed after base write", 64'(win_en), 64'd0);
    expect_local(1'b0, 40'h100, 4'd4, "R5");
    commit_expect(3'b000, "R5");
    cfg_write(3'd4, 40'hFF);
    chk(!win_en, "R5", "closed after mask write", 64'(win_en), 64'd0);
    commit_expect(3'b000, "R5");

    // R8 / R9 boundaries
    expect_local(1'b0, size_v, 4'd1, "R8");
    expect_route(1'b0, size_v - 1, 4'd1, 64'd0, port_of(size_v - 1, 0, 4), "R8");
    expect_local(1'b0, 40'h200, 4'd0, "R8");
    expect_local(1'b0, 40'h200, 4'd9, "R8");
    expect_local(1'b1, 40'h200, 4'd9, "R9");
    cfg_write(3'd4, 40'hFD);
    commit_expect(3'b000, "R8");
    begin
      logic [39:0] off1;
      off1 = 40'h0;
      while (port_of(off1, 0, 4) != 1) off1 = off1 + 40'd256;
      expect_local(1'b0, off1, 4'd2, "R8");
      expect_local(1'b1, off1, 4'd2, "R9");
      expect_route(1'b1, off1 + 40'd256, 4'd2, 64'h55AA, port_of(off1 + 40'd256, 0, 4), "R8");
    end
    cfg_write(3'd5, 40'd0);
    chk(!win_en && cfg_err == 0, "R4", "decommit", 64'(win_en), 64'd0);
    expect_local(1'b1, 40'h300, 4'd8, "R9");
    expect_local(1'b0, 40'h300, 4'd8, "R8");

    // R10 every length at unaligned offsets, single target
    cfg_write(3'd4, 40'hFF);
    cfg_write(3'd3, 40'd1);
    commit_expect(3'b000, "R10");
    for (int b = 1; b <= 8; b++) begin
      logic [39:0] off;
      off = 40'(16'h0100 + b);
      expect_route(b[0], off, 4'(b), 64'h0807_0605_0403_0201 * 64'(b), 0, "R10");
    end

    // R11 collision: downstream responses overlap a local error
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_tag = 8'h55; req_offset = 40'h10; req_bytes = 4'd0;
    @(negedge clk);
    req_valid = 1'b0;
    ds_rsp_valid = 1'b1; ds_rsp_tag = 8'hA0; ds_rsp_data = 64'h1111; ds_rsp_err = 1'b0;
    for (int i = 0; i < 3; i++) begin
      logic [7:0] et;
      et = 8'hA0 + 8'(i);
      @(negedge clk);
      chk(rsp_valid && rsp_tag == et && rsp_data == 64'h1111 * 64'(i + 1) && !rsp_err,
          "R11", "downstream first", 64'(rsp_tag), 64'(et));
      ds_rsp_tag = et + 8'd1; ds_rsp_data = 64'h1111 * 64'(i + 2);
    end
    ds_rsp_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid && rsp_tag == 8'h55 && rsp_data == 0 && rsp_err, "R11", "local after",
        64'(rsp_tag), 64'h55);
    @(negedge clk);
    chk(!rsp_valid, "R11", "single local", 64'(rsp_valid), 64'd0);

    // R11 queue fill under a continuous downstream stream
    begin
      int acc;
      int got;
      bit order_ok;
      acc = 0;
      ds_rsp_valid = 1'b1; ds_rsp_tag = 8'hEE; ds_rsp_data = 64'd0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (req_ready) begin
          req_valid = 1'b1; req_write = 1'b0; req_tag = 8'h60 + 8'(acc);
          req_bytes = 4'd0; req_offset = 40'h20;
          acc++;
        end else begin
          req_valid = 1'b0;
        end
      end
      req_valid = 1'b0;
      chk(acc == LQ_DEPTH, "R11", "accepted before stall", 64'(acc), 64'(LQ_DEPTH));
      @(negedge clk);
      chk(!req_ready, "R11", "ready low when full", 64'(req_ready), 64'd0);
      ds_rsp_valid = 1'b0;
      got = 0; order_ok = 1'b1;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (rsp_valid && rsp_tag != 8'hEE) begin
          if (rsp_tag != 8'h60 + 8'(got) || rsp_data != 0 || !rsp_err) order_ok = 1'b0;
          got++;
        end
      end
      chk(got == LQ_DEPTH && order_ok, "R11", "drain in order", 64'(got), 64'(LQ_DEPTH));
      chk(req_ready, "R11", "ready after drain", 64'(req_ready), 64'd1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule